// File: doc/BRIEF.md
# Two-Wire Byte-Addressed Nonvolatile Store Slave

This block is the slave side of a two-wire serial bus in front of a 128-byte storage array, held here as on-chip registers. It receives already synchronized samples of the bus clock and the data line and a write-enable level. It answers on an open-drain data output, where a 1 releases the line and a 0 pulls it low. A host addresses the block with a 4-bit device code. It can then set a word address and stream bytes into a page, or read from the current address or from a chosen address. Reads can run on through the whole array.

Write data is gathered in an 8-byte page buffer with a per-byte valid mask. It reaches the array only when a stop condition closes the write. A commit starts a self-timed write cycle, modelled as a busy counter. While that counter runs, the slave ignores its own address. The write-enable input gates the commit but never gates address setting, so a random read still works with writes locked.

Top module: `twowire_nvstore`

## Requirements
- R1: A start is the data line falling while the bus clock stays high, and a stop is the data line rising while the bus clock stays high. Bits clocked in before any start are ignored and get no acknowledge. Out of a command the data output is released (1).
- R2: The first byte after a start is the device byte: bits 7..4 must equal 1010, bits 3..1 are ignored, and bit 0 selects read (1) or write (0). Any other code gets no acknowledge, and the slave stays silent until the next start.
- R3: Incoming bits are taken on bus-clock rising edges, most significant bit first. The slave changes its output only after bus-clock falling edges, so its output is steady while the bus clock is high. An acknowledge holds the line low for the whole 9th clock of a byte.
- R4: In a write, the byte after the device byte is a 7-bit word address (bits 6..0), and every address and data byte is acknowledged. Only the locations actually received are changed.
- R5: Successive data bytes of one write go to consecutive locations. Only address bits 2..0 advance and bits 6..3 stay fixed, so a ninth or later byte wraps within the 8-byte page and overwrites an earlier one.
- R6: Buffered write data reaches the array only when a stop ends the write. A repeated start discards it.
- R7: With the write-enable input low at the stop, no location changes and no write cycle starts. The word address is still taken as the current address.
- R8: Each byte read comes from the current address, which then advances by one over all 7 bits and wraps from 7Fh to 00h.
- R9: After a write sequence, a current-address read returns the location named by that sequence's word address.
- R10: In a read, a master acknowledge (line low in the 9th clock) makes the slave send the next byte. Without it, the slave releases the line and sends nothing until the next start.
- R11: A random read is a write header with only a word address, then a repeated start and a read header. It returns the byte at that word address.
- R12: For BUSY_CYCLES clock cycles after a commit, the slave does not acknowledge its device byte.
- R13: After reset every location holds 00h, the current address is 00h and the data output is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized bus clock sample |
| sda_i | input | 1 | Synchronized data line sample (wired-AND bus level) |
| wr_en_i | input | 1 | Write-enable level; low blocks commits to the array |
| sda_o | output | 1 | Open-drain data drive: 0 pulls low, 1 releases |

## Verification
The main function is tried with several patterns: a single-byte write, a ten-byte write that starts mid-page, a two-byte partial write, and writes with the enable low. Together they separate wrap within the page from a carry into bit 3, and a masked commit from a whole-page commit. Read patterns separate the two ways of setting the current address, by a word address and by a preceding read, and probe the roll from 7Fh to 00h. A repeated start after buffered data, a header sent with no start, a foreign device code and a probe during the write cycle show which events the slave must refuse. A read ended without a master acknowledge shows whether the slave truly lets go of the line.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_WADDR,
        ST_WDATA,
        ST_RDATA
    } nvs_state_e;

    localparam logic [3:0] NVS_DEV_CODE = 4'b1010;

    localparam int NVS_BYTE_BITS = 8;

endpackage

// File: rtl/nvs_bus_cond.sv
module nvs_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic scl;
        logic sda;
    } line_t;

    line_t line_d, line_q;

    always_comb begin
        line_d     = line_q;
        line_d.scl = scl_i;
        line_d.sda = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            line_q <= line_d;
        end
    end

    assign scl_rise_o = !line_q.scl && scl_i;
    assign scl_fall_o = line_q.scl && !scl_i;
    assign start_o    = line_q.scl && scl_i && line_q.sda && !sda_i;
    assign stop_o     = line_q.scl && scl_i && !line_q.sda && sda_i;

    // R1: start and stop only while the clock is held high, never together with a clock edge
    a_r1_cond_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o || stop_o) |-> !(scl_rise_o || scl_fall_o));

endmodule

// File: rtl/nvs_wr_timer.sv
module nvs_wr_timer #(
    parameter int unsigned BUSY_CYCLES = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic busy_o
);

    localparam int unsigned CNT_W = $clog2(BUSY_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(BUSY_CYCLES);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = CNT_TOP;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy_o = (cnt_q != '0);

    a_r12_busy_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> busy_o);

    a_r12_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_TOP);

endmodule

// File: rtl/nvs_page_buf.sv
module nvs_page_buf #(
    parameter int PAGE_W = 3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                clr_i,
    input  logic                                wr_i,
    input  logic [PAGE_W-1:0]                   idx_i,
    input  logic [7:0]                          din_i,
    output logic [(1<<PAGE_W)-1:0][7:0]         data_o,
    output logic [(1<<PAGE_W)-1:0]              mask_o
);

    localparam int PAGE_BYTES = 1 << PAGE_W;

    typedef struct packed {
        logic [PAGE_BYTES-1:0][7:0] data;
        logic [PAGE_BYTES-1:0]      mask;
    } pbuf_t;

    pbuf_t buf_d, buf_q;
    logic [PAGE_BYTES-1:0] slot_hit;

    for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
        assign slot_hit[s] = wr_i && (idx_i == PAGE_W'(s));
    end

    always_comb begin
        buf_d = buf_q;
        if (clr_i) begin
            buf_d.mask = '0;
        end else begin
            for (int s = 0; s < PAGE_BYTES; s++) begin
                if (slot_hit[s]) begin
                    buf_d.data[s] = din_i;
                    buf_d.mask[s] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

    assign data_o = buf_q.data;
    assign mask_o = buf_q.mask;

    a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (mask_o == '0));

    a_r5_slot_filled: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !clr_i) |=> (mask_o[$past(idx_i)] && data_o[$past(idx_i)] == $past(din_i)));

endmodule

// File: rtl/nvs_array.sv
module nvs_array #(
    parameter int ADDR_W = 7,
    parameter int PAGE_W = 3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                commit_i,
    input  logic [ADDR_W-PAGE_W-1:0]            page_i,
    input  logic [(1<<PAGE_W)-1:0][7:0]         wdata_i,
    input  logic [(1<<PAGE_W)-1:0]              wmask_i,
    input  logic [ADDR_W-1:0]                   rd_addr_i,
    output logic [7:0]                          rd_data_o
);

    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];
    logic [PAGE_BYTES-1:0] slot_we;

    for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_we
        assign slot_we[s] = commit_i && wmask_i[s];
    end

    always_comb begin
        mem_d = mem_q;
        for (int s = 0; s < PAGE_BYTES; s++) begin
            if (slot_we[s]) begin
                mem_d[{page_i, PAGE_W'(s)}] = wdata_i[s];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];

endmodule

// File: rtl/twowire_nvstore.sv
module twowire_nvstore #(
    parameter int          ADDR_W      = 7,
    parameter int          PAGE_W      = 3,
    parameter int unsigned BUSY_CYCLES = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wr_en_i,
    output logic sda_o
);

    import nvs_pkg::*;

    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int HI_W       = ADDR_W - PAGE_W;

    typedef struct packed {
        nvs_state_e         st;
        logic [3:0]         bits;
        logic [7:0]         sh;
        logic [ADDR_W-1:0]  cur;
        logic [ADDR_W-1:0]  ptr;
        logic               macked;
        logic               sda;
    } fsm_t;

    localparam fsm_t FSM_RST = '{
        st:     ST_IDLE,
        bits:   4'd0,
        sh:     8'd0,
        cur:    '0,
        ptr:    '0,
        macked: 1'b0,
        sda:    1'b1
    };

    fsm_t fsm_d, fsm_q;

    logic scl_rise, scl_fall, start_det, stop_det;
    logic busy;
    logic buf_clr, buf_wr, commit;
    logic [PAGE_BYTES-1:0][7:0] buf_data;
    logic [PAGE_BYTES-1:0]      buf_mask;
    logic [7:0]                 rd_data;

    nvs_bus_cond u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    nvs_page_buf #(.PAGE_W(PAGE_W)) u_pbuf (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (buf_clr),
        .wr_i   (buf_wr),
        .idx_i  (fsm_q.ptr[PAGE_W-1:0]),
        .din_i  (fsm_q.sh),
        .data_o (buf_data),
        .mask_o (buf_mask)
    );

    nvs_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit_i  (commit),
        .page_i    (fsm_q.ptr[ADDR_W-1:PAGE_W]),
        .wdata_i   (buf_data),
        .wmask_i   (buf_mask),
        .rd_addr_i (fsm_q.cur),
        .rd_data_o (rd_data)
    );

    nvs_wr_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (commit),
        .busy_o (busy)
    );

    always_comb begin
        fsm_d   = fsm_q;
        buf_clr = 1'b0;
        buf_wr  = 1'b0;
        commit  = 1'b0;

        if (stop_det) begin
            fsm_d.st   = ST_IDLE;
            fsm_d.bits = 4'd0;
            fsm_d.sda  = 1'b1;
            commit     = wr_en_i && (buf_mask != '0);
            buf_clr    = 1'b1;
        end else if (start_det) begin
            fsm_d.st   = ST_DEV;
            fsm_d.bits = 4'd0;
            fsm_d.sda  = 1'b1;
            buf_clr    = 1'b1;
        end else begin
            unique case (fsm_q.st)
                ST_IDLE: begin
                    fsm_d.sda = 1'b1;
                end

                ST_DEV, ST_WADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        if (fsm_q.bits < 4'd8) begin
                            fsm_d.sh   = {fsm_q.sh[6:0], sda_i};
                            fsm_d.bits = fsm_q.bits + 4'd1;
                        end else if (fsm_q.bits == 4'd8) begin
                            fsm_d.bits = 4'd9;
                        end
                    end else if (scl_fall) begin
                        if (fsm_q.bits == 4'd8) begin
                            // acknowledge decision for the byte just received
                            if (fsm_q.st == ST_DEV) begin
                                if ((fsm_q.sh[7:4] == NVS_DEV_CODE) && !busy) begin
                                    fsm_d.sda = 1'b0;
                                end else begin
                                    fsm_d.sda = 1'b1;
                                    fsm_d.st  = ST_IDLE;
                                end
                            end else begin
                                fsm_d.sda = 1'b0;
                                if (fsm_q.st == ST_WDATA) begin
                                    buf_wr = 1'b1;
                                end
                            end
                        end else if (fsm_q.bits == 4'd9) begin
                            fsm_d.sda  = 1'b1;
                            fsm_d.bits = 4'd0;
                            if (fsm_q.st == ST_DEV) begin
                                if (fsm_q.sh[0]) begin
                                    fsm_d.st  = ST_RDATA;
                                    fsm_d.sh  = rd_data;
                                    fsm_d.sda = rd_data[7];
                                    fsm_d.cur = fsm_q.cur + 1'b1;
                                end else begin
                                    fsm_d.st = ST_WADDR;
                                end
                            end else if (fsm_q.st == ST_WADDR) begin
                                fsm_d.cur = fsm_q.sh[ADDR_W-1:0];
                                fsm_d.ptr = fsm_q.sh[ADDR_W-1:0];
                                fsm_d.st  = ST_WDATA;
                            end else begin
                                fsm_d.ptr = {fsm_q.ptr[ADDR_W-1:PAGE_W],
                                             fsm_q.ptr[PAGE_W-1:0] + 1'b1};
                            end
                        end
                    end
                end

                ST_RDATA: begin
                    if (scl_rise) begin
                        if (fsm_q.bits < 4'd8) begin
                            fsm_d.bits = fsm_q.bits + 4'd1;
                        end else if (fsm_q.bits == 4'd8) begin
                            fsm_d.macked = !sda_i;
                            fsm_d.bits   = 4'd9;
                        end
                    end else if (scl_fall) begin
                        if ((fsm_q.bits >= 4'd1) && (fsm_q.bits <= 4'd7)) begin
                            fsm_d.sh  = {fsm_q.sh[6:0], 1'b0};
                            fsm_d.sda = fsm_q.sh[6];
                        end else if (fsm_q.bits == 4'd8) begin
                            fsm_d.sda = 1'b1;
                        end else if (fsm_q.bits == 4'd9) begin
                            if (fsm_q.macked) begin
                                fsm_d.sh   = rd_data;
                                fsm_d.sda  = rd_data[7];
                                fsm_d.cur  = fsm_q.cur + 1'b1;
                                fsm_d.bits = 4'd0;
                            end else begin
                                fsm_d.sda = 1'b1;
                                fsm_d.st  = ST_IDLE;
                            end
                        end
                    end
                end

                default: begin
                    fsm_d = FSM_RST;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= FSM_RST;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign sda_o = fsm_q.sda;

    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_IDLE) |-> sda_o);

    a_r3_data_ack_low: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_WDATA && fsm_q.bits == 4'd9) |-> !sda_o);

    a_r3_bit_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_q.bits <= 4'd9);

    a_r8_read_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_RDATA && scl_fall && fsm_q.bits == 4'd9 && fsm_q.macked && !stop_det)
        |=> (fsm_q.cur == ADDR_W'($past(fsm_q.cur) + 1'b1)));

    a_r12_busy_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_DEV && scl_fall && fsm_q.bits == 4'd8 && busy)
        |=> (sda_o && fsm_q.st == ST_IDLE));

    a_r6_stop_clears_page: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det || start_det) |=> (buf_mask == '0));

    if (HI_W < 1) begin : g_bad_cfg
        initial begin
            $display("twowire_nvstore: PAGE_W must be smaller than ADDR_W");
        end
    end

endmodule

// File: tb/twowire_nvstore_tb.sv
module twowire_nvstore_tb;

    localparam int Q    = 4;
    localparam int BUSY = 256;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic scl   = 1'b1;
    logic sda_m = 1'b1;
    logic wr_en = 1'b1;
    logic sda_o;
    logic sda_bus;
    logic done  = 1'b0;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [7:0] v;
        string      tag;
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] act_q[$];

    assign sda_bus = sda_m & sda_o;

    always #4 clk = ~clk;

    twowire_nvstore #(.BUSY_CYCLES(BUSY)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl),
        .sda_i   (sda_bus),
        .wr_en_i (wr_en),
        .sda_o   (sda_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic expect_byte(input logic [7:0] v, input string tag);
        exp_t e;
        e.v   = v;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic bus_start();
        scl = 1'b0;   tick(Q);
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic bus_stop();
        scl = 1'b0;   tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl = 1'b1;   tick(Q);
            scl = 1'b0;   tick(1);
        end
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(1);
        acked = !sda_bus;
        tick(Q - 2);
        check(sda_bus == !acked, "R3 acknowledge held through clock high", int'(sda_bus), int'(!acked));
        tick(1);
        scl = 1'b0;   tick(1);
    endtask

    task automatic recv_byte(input bit mack);
        logic [7:0] b;
        bit steady;
        steady = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl = 1'b1; tick(1);
            b[i] = sda_bus;
            tick(Q - 1);
            if (sda_bus != b[i]) steady = 1'b0;
            scl = 1'b0;
        end
        check(steady, "R3 output steady while clock high", int'(steady), 1);
        sda_m = !mack; tick(Q);
        scl = 1'b1;    tick(Q);
        scl = 1'b0;    tick(1);
        sda_m = 1'b1;
        act_q.push_back(b);
    endtask

    task automatic expect_ack(input bit acked, input bit want, input string tag);
        check(acked == want, tag, int'(acked), int'(want));
    endtask

    task automatic do_write(input logic [7:0] hdr, input logic [6:0] a,
                            input logic [7:0] d[10], input int n, input string tag);
        bit ak;
        bus_start();
        send_byte(hdr, ak);
        expect_ack(ak, 1'b1, {tag, " device byte acknowledged"});
        send_byte({1'b0, a}, ak);
        expect_ack(ak, 1'b1, "R4 word address acknowledged");
        for (int i = 0; i < n; i++) begin
            send_byte(d[i], ak);
            expect_ack(ak, 1'b1, "R4 data byte acknowledged");
        end
        bus_stop();
    endtask

    task automatic rand_read(input logic [6:0] a, input int n);
        bit ak;
        bus_start();
        send_byte(8'hA0, ak);
        expect_ack(ak, 1'b1, "R11 write header acknowledged");
        send_byte({1'b0, a}, ak);
        expect_ack(ak, 1'b1, "R11 word address acknowledged");
        bus_start();
        send_byte(8'hA1, ak);
        expect_ack(ak, 1'b1, "R11 read header acknowledged");
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1);
        end
        bus_stop();
    endtask

    task automatic cur_read(input logic [7:0] hdr, input int n);
        bit ak;
        bus_start();
        send_byte(hdr, ak);
        expect_ack(ak, 1'b1, "R2 read header acknowledged");
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1);
        end
        bus_stop();
    endtask

    task automatic probe(input logic [7:0] hdr, input bit want, input string tag);
        bit ak;
        bus_start();
        send_byte(hdr, ak);
        expect_ack(ak, want, tag);
        bus_stop();
    endtask

    // scoreboard monitor: pairs each received byte with the next expected one
    initial begin
        forever begin
            wait (act_q.size() > 0);
            begin
                logic [7:0] a;
                exp_t e;
                a = act_q.pop_front();
                if (exp_q.size() == 0) begin
                    check(1'b0, "scoreboard byte with no expectation", int'(a), 0);
                end else begin
                    e = exp_q.pop_front();
                    check(a == e.v, e.tag, int'(a), int'(e.v));
                end
            end
        end
    end

    initial begin
        tick(150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d[10];
        bit ak;
        for (int i = 0; i < 10; i++) d[i] = 8'h00;

        tick(5);
        rst_n = 1'b1;
        tick(3);
        check(sda_bus == 1'b1, "R13 line released after reset", int'(sda_bus), 1);

        // R13: fresh array and current address zero
        expect_byte(8'h00, "R13 first current read after reset");
        cur_read(8'hA1, 1);

        // R1: a header clocked in with no start is ignored
        send_byte(8'hA0, ak);
        expect_ack(ak, 1'b0, "R1 no acknowledge without start");
        bus_stop();

        // R2: foreign device code
        probe(8'hB0, 1'b0, "R2 foreign code refused");

        // R4 byte write with don't-care bits set, then R12 busy refusal
        d[0] = 8'h3C;
        do_write(8'hAE, 7'h10, d, 1, "R2");
        probe(8'hA1, 1'b0, "R12 device byte refused while busy");
        tick(BUSY + 40);
        expect_byte(8'h3C, "R9 current read after write returns written location");
        cur_read(8'hAD, 1);

        // R11 random read, then R8 step to n+1
        expect_byte(8'h3C, "R11 random read of 10h");
        rand_read(7'h10, 1);
        expect_byte(8'h00, "R8 current read after read at 10h gives 11h");
        cur_read(8'hA1, 1);

        // R5 page write of ten bytes starting mid-page at 1Dh
        for (int i = 0; i < 10; i++) d[i] = 8'h40 + 8'(i);
        do_write(8'hA0, 7'h1D, d, 10, "R5");
        tick(BUSY + 40);
        expect_byte(8'h43, "R5 page slot 18h");
        expect_byte(8'h44, "R5 page slot 19h");
        expect_byte(8'h45, "R5 page slot 1Ah");
        expect_byte(8'h46, "R5 page slot 1Bh");
        expect_byte(8'h47, "R5 page slot 1Ch");
        expect_byte(8'h48, "R5 page slot 1Dh overwritten");
        expect_byte(8'h49, "R5 page slot 1Eh overwritten");
        expect_byte(8'h42, "R5 page slot 1Fh");
        rand_read(7'h18, 8);
        expect_byte(8'h00, "R5 next page untouched");
        rand_read(7'h20, 1);

        // R4 partial page: only received bytes change
        d[0] = 8'hA1;
        d[1] = 8'hA2;
        do_write(8'hA0, 7'h28, d, 2, "R4");
        tick(BUSY + 40);
        expect_byte(8'h00, "R4 location below write untouched");
        expect_byte(8'hA1, "R4 first written byte");
        expect_byte(8'hA2, "R4 second written byte");
        expect_byte(8'h00, "R4 location above write untouched");
        rand_read(7'h27, 4);

        // R7 write with enable low: no change, no busy, address still set
        wr_en = 1'b0;
        d[0] = 8'h99;
        do_write(8'hA0, 7'h18, d, 1, "R7");
        probe(8'hA0, 1'b1, "R7 no write cycle started");
        wr_en = 1'b1;
        expect_byte(8'h43, "R7 blocked write left 18h and set address");
        cur_read(8'hA1, 1);

        // R6 repeated start discards buffered data
        bus_start();
        send_byte(8'hA0, ak);
        expect_ack(ak, 1'b1, "R6 header acknowledged");
        send_byte(8'h40, ak);
        expect_ack(ak, 1'b1, "R6 address acknowledged");
        send_byte(8'h55, ak);
        expect_ack(ak, 1'b1, "R6 data acknowledged");
        bus_start();
        send_byte(8'hA1, ak);
        expect_ack(ak, 1'b1, "R6 read header acknowledged");
        expect_byte(8'h00, "R6 data not written before stop");
        recv_byte(1'b0);
        bus_stop();
        probe(8'hA0, 1'b1, "R6 no write cycle after discarded data");
        expect_byte(8'h00, "R6 location 40h still empty");
        rand_read(7'h40, 1);

        // R8 wrap from 7Fh to 00h
        d[0] = 8'h11;
        do_write(8'hA0, 7'h00, d, 1, "R8");
        tick(BUSY + 40);
        d[0] = 8'hEE;
        do_write(8'hA0, 7'h7F, d, 1, "R8");
        tick(BUSY + 40);
        expect_byte(8'hEE, "R8 top of array");
        expect_byte(8'h11, "R8 wrapped to 00h");
        rand_read(7'h7F, 2);
        expect_byte(8'h00, "R8 address after wrap read is 01h");
        cur_read(8'hA1, 1);

        // R10 no master acknowledge: slave lets go of the line
        bus_start();
        send_byte(8'hA0, ak);
        expect_ack(ak, 1'b1, "R10 header acknowledged");
        send_byte(8'h10, ak);
        expect_ack(ak, 1'b1, "R10 address acknowledged");
        bus_start();
        send_byte(8'hA1, ak);
        expect_ack(ak, 1'b1, "R10 read header acknowledged");
        expect_byte(8'h3C, "R10 byte before missing acknowledge");
        recv_byte(1'b0);
        expect_byte(8'hFF, "R10 line released after missing acknowledge");
        recv_byte(1'b0);
        bus_stop();

        tick(20);
        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule